// File: doc/BRIEF.md
# Interrupt Pin Sampling and Service Unit

This unit sits between the request lines of a multi-pin interrupt controller and the path that carries interrupt messages to processors. Each change of a request line arrives as an event naming a pin index and a raw level. The unit turns the raw level into an effective level using the pin's configured polarity, keeps one request bit per pin, and decides whether the event starts a delivery or is merged into one already made (coalesced). Each in-range event returns a status one cycle later that says which of the two happened.

The routing table is not held here. Its fields arrive as flat input vectors, one slice per pin. The only thing the unit writes back is a one-cycle request to set a pin's remote-acknowledge-pending flag, raised when a level-triggered message is accepted downstream. End-of-interrupt handling lives elsewhere and comes back as a re-service request for one pin. Accepted deliveries wait in a pending bit per pin. A valid/ready port offers them one at a time, lowest pin index first. Each message carries the vector, destination, destination mode, delivery mode and trigger mode.

Top module: `irq_pin_service`

## Requirements
- R1: On an in-range event the pin's request bit takes the effective level, which is the raw level XOR the polarity bit (1 means active low). The new value shows on `irr` one cycle after the event.
- R2: An event whose effective level is 0 clears the request bit. It creates no delivery, and its status reports neither sent nor coalesced.
- R3: For an edge-triggered pin (trigger bit 0), an event with effective level 1 is serviced only if the request bit was 0 before the event. Otherwise the status reports coalesced.
- R4: For a level-triggered pin (trigger bit 1), an event with effective level 1 is serviced only if the remote flag input is 0 and no delivery for that pin is pending. Otherwise the status reports coalesced.
- R5: Servicing a masked pin (mask bit 1) creates no pending delivery. Its status reports neither sent nor coalesced, and the request bit still follows R1.
- R6: In the cycle a level-triggered pin's message is accepted (`msg_valid` and `msg_ready` both high), bit i of `rirr_set` is 1 for that pin. At all other times it is 0.
- R7: `msg_vector`, `msg_dest`, `msg_logical`, `msg_dmode` and `msg_level` equal the table fields of the pin shown on `msg_pin`.
- R8: `msg_valid` stays high until the message is accepted. When several pins are pending, the lowest index is offered first.
- R9: A message for pin 0 always carries physical destination mode (`msg_logical` = 0) and destination `BOOT_DEST`, whatever its table entry holds.
- R10: An event or re-service request whose index is NUM_PINS or more changes no request bit, creates no delivery and produces no status.
- R11: A re-service request for a level-triggered pin whose request bit is 1, whose remote flag is 0 and which has nothing pending services the pin, subject to its mask.
- R12: The status outputs `st_valid`, `st_sent` and `st_coal` are registered one cycle after each in-range event. `st_sent` and `st_coal` are never both 1.
- R13: After reset all request bits are 0, nothing is pending and no status is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_valid | input | 1 | Pin level event present |
| ev_idx | input | IDX_W | Pin index of the event |
| ev_level | input | 1 | Raw level of the pin |
| rs_valid | input | 1 | Re-service request present |
| rs_idx | input | IDX_W | Pin index to re-service |
| cfg_vector | input | NUM_PINS*VEC_W | Per-pin vector |
| cfg_dest | input | NUM_PINS*DEST_W | Per-pin destination |
| cfg_dmode | input | NUM_PINS*3 | Per-pin delivery mode |
| cfg_logical | input | NUM_PINS | Per-pin logical destination mode |
| cfg_active_low | input | NUM_PINS | Per-pin polarity |
| cfg_level_trig | input | NUM_PINS | Per-pin trigger mode, 1 = level |
| cfg_mask | input | NUM_PINS | Per-pin mask |
| cfg_rirr | input | NUM_PINS | Per-pin remote-acknowledge-pending flag |
| irr | output | NUM_PINS | Request bits |
| rirr_set | output | NUM_PINS | Request to set the remote flag |
| st_valid | output | 1 | Event status valid |
| st_sent | output | 1 | Event produced a delivery |
| st_coal | output | 1 | Event was coalesced |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message accepted |
| msg_pin | output | IDX_W | Pin of the offered message |
| msg_vector | output | VEC_W | Vector |
| msg_dest | output | DEST_W | Destination |
| msg_logical | output | 1 | Logical destination mode |
| msg_dmode | output | 3 | Delivery mode |
| msg_level | output | 1 | Trigger mode |

## Verification
The bench builds the unit with 24 pins, a 5-bit index, 8-bit vectors and destinations, and boot destination 0x5A. A 5-bit index can name pins 24 to 31, so random events reach the out-of-range path of R10 as part of normal traffic. Pin 0 is the lowest index, so in the random phase its fixed routing meets the lowest-first order often. The bench also plays the register block: it sets the remote flags from `rirr_set` and clears them together with re-service requests, which exercises the coalescing rules for level pins.

// File: rtl/irqsvc_pkg.sv
package irqsvc_pkg;
   localparam int DMODE_W = 3;

   typedef enum logic {
      TRIG_EDGE  = 1'b0,
      TRIG_LEVEL = 1'b1
   } trig_e;

   typedef struct packed {
      logic sent;
      logic coal;
   } ev_outcome_t;
endpackage

// File: rtl/irqsvc_pin.sv
module irqsvc_pin
   import irqsvc_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ev_hit,
   input  logic        ev_lvl,
   input  logic        rs_hit,
   input  logic        active_low,
   input  logic        level_trig,
   input  logic        mask,
   input  logic        rirr,
   input  logic        take,
   output logic        irr_q,
   output logic        pend_q,
   output ev_outcome_t outcome
);
   logic eff, is_lvl, ev_ok, rs_ok, fire;

   always_comb begin
      eff     = ev_lvl ^ active_low;
      is_lvl  = (trig_e'(level_trig) == TRIG_LEVEL);
      ev_ok   = is_lvl ? !(rirr || pend_q) : !irr_q;
      rs_ok   = rs_hit && is_lvl && irr_q && !rirr && !pend_q;
      fire    = ((ev_hit && eff && ev_ok) || rs_ok) && !mask;
      outcome.sent = ev_hit && eff && ev_ok && !mask;
      outcome.coal = ev_hit && eff && !ev_ok;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irr_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         if (ev_hit)
            irr_q <= eff;
         if (fire)
            pend_q <= 1'b1;
         else if (take)
            pend_q <= 1'b0;
      end
   end

   AST_MASKED_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q) |-> $past(!mask)); // R5
   AST_EDGE_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pend_q) && $past(!level_trig)) |-> $past(!irr_q)); // R3
   AST_LEVEL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pend_q) && $past(level_trig)) |-> $past(!rirr)); // R4
endmodule

// File: rtl/irqsvc_arb.sv
module irqsvc_arb #(
   parameter int N     = 24,
   parameter int IDX_W = 5,
   parameter int IMPL  = 0
) (
   input  logic [N-1:0]     req,
   output logic [N-1:0]     gnt,
   output logic [IDX_W-1:0] idx
);
   generate
      if (IMPL != 0 && IMPL != 1) begin : g_bad_impl
         $error("irqsvc_arb: IMPL must be 0 or 1");
      end
      if (IMPL == 0) begin : g_twos
         assign gnt = req & (~req + N'(1));
      end else begin : g_scan
         always_comb begin
            logic found;
            found = 1'b0;
            gnt   = '0;
            for (int i = 0; i < N; i++) begin
               if (req[i] && !found) begin
                  gnt[i] = 1'b1;
                  found  = 1'b1;
               end
            end
         end
      end
   endgenerate

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++)
         if (gnt[i])
            idx = idx | IDX_W'(i);
   end
endmodule

// File: rtl/irq_pin_service.sv
module irq_pin_service
   import irqsvc_pkg::*;
#(
   parameter int              NUM_PINS   = 24,
   parameter int              VEC_W      = 8,
   parameter int              DEST_W     = 8,
   parameter int              IDX_W      = $clog2(NUM_PINS),
   parameter int              ARB_IMPL   = 0,
   parameter bit              PIN0_FIXED = 1'b1,
   parameter logic [DEST_W-1:0] BOOT_DEST = '0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         ev_valid,
   input  logic [IDX_W-1:0]             ev_idx,
   input  logic                         ev_level,
   input  logic                         rs_valid,
   input  logic [IDX_W-1:0]             rs_idx,
   input  logic [NUM_PINS*VEC_W-1:0]    cfg_vector,
   input  logic [NUM_PINS*DEST_W-1:0]   cfg_dest,
   input  logic [NUM_PINS*DMODE_W-1:0]  cfg_dmode,
   input  logic [NUM_PINS-1:0]          cfg_logical,
   input  logic [NUM_PINS-1:0]          cfg_active_low,
   input  logic [NUM_PINS-1:0]          cfg_level_trig,
   input  logic [NUM_PINS-1:0]          cfg_mask,
   input  logic [NUM_PINS-1:0]          cfg_rirr,
   output logic [NUM_PINS-1:0]          irr,
   output logic [NUM_PINS-1:0]          rirr_set,
   output logic                         st_valid,
   output logic                         st_sent,
   output logic                         st_coal,
   output logic                         msg_valid,
   input  logic                         msg_ready,
   output logic [IDX_W-1:0]             msg_pin,
   output logic [VEC_W-1:0]             msg_vector,
   output logic [DEST_W-1:0]            msg_dest,
   output logic                         msg_logical,
   output logic [DMODE_W-1:0]           msg_dmode,
   output logic                         msg_level
);
   generate
      if (NUM_PINS < 2) begin : g_chk_pins
         $error("irq_pin_service: NUM_PINS must be at least 2");
      end
      if (IDX_W < $clog2(NUM_PINS)) begin : g_chk_idx
         $error("irq_pin_service: IDX_W too narrow for NUM_PINS");
      end
      if (VEC_W < 1 || DEST_W < 1) begin : g_chk_fields
         $error("irq_pin_service: field widths must be positive");
      end
   endgenerate

   logic [NUM_PINS-1:0] ev_hit, rs_hit, pend, gnt, sent_v, coal_v;
   ev_outcome_t         oc [NUM_PINS];
   logic                take, ev_in_range;
   logic [IDX_W-1:0]    g_idx;
   logic [DEST_W-1:0]   dest_raw;
   logic                logical_raw;

   assign take        = msg_valid && msg_ready;
   assign ev_in_range = ev_valid && (int'(ev_idx) < NUM_PINS);

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      assign ev_hit[i] = ev_valid && (ev_idx == IDX_W'(i));
      assign rs_hit[i] = rs_valid && (rs_idx == IDX_W'(i));
      assign sent_v[i] = oc[i].sent;
      assign coal_v[i] = oc[i].coal;

      irqsvc_pin u_pin (
         .clk        (clk),
         .rst_n      (rst_n),
         .ev_hit     (ev_hit[i]),
         .ev_lvl     (ev_level),
         .rs_hit     (rs_hit[i]),
         .active_low (cfg_active_low[i]),
         .level_trig (cfg_level_trig[i]),
         .mask       (cfg_mask[i]),
         .rirr       (cfg_rirr[i]),
         .take       (take && gnt[i]),
         .irr_q      (irr[i]),
         .pend_q     (pend[i]),
         .outcome    (oc[i])
      );
   end

   irqsvc_arb #(
      .N     (NUM_PINS),
      .IDX_W (IDX_W),
      .IMPL  (ARB_IMPL)
   ) u_arb (
      .req (pend),
      .gnt (gnt),
      .idx (g_idx)
   );

   assign msg_valid = |pend;
   assign msg_pin   = g_idx;
   assign rirr_set  = take ? (gnt & cfg_level_trig) : '0;

   always_comb begin
      msg_vector  = '0;
      dest_raw    = '0;
      logical_raw = 1'b0;
      msg_dmode   = '0;
      msg_level   = 1'b0;
      for (int i = 0; i < NUM_PINS; i++) begin
         if (gnt[i]) begin
            msg_vector  = cfg_vector[i*VEC_W +: VEC_W];
            dest_raw    = cfg_dest[i*DEST_W +: DEST_W];
            logical_raw = cfg_logical[i];
            msg_dmode   = cfg_dmode[i*DMODE_W +: DMODE_W];
            msg_level   = cfg_level_trig[i];
         end
      end
   end

   generate
      if (PIN0_FIXED) begin : g_pin0_fixed
         assign msg_dest    = gnt[0] ? BOOT_DEST : dest_raw;
         assign msg_logical = gnt[0] ? 1'b0 : logical_raw;
      end else begin : g_pin0_table
         assign msg_dest    = dest_raw;
         assign msg_logical = logical_raw;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_valid <= 1'b0;
         st_sent  <= 1'b0;
         st_coal  <= 1'b0;
      end else begin
         st_valid <= ev_in_range;
         st_sent  <= |sent_v;
         st_coal  <= |coal_v;
      end
   end

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt)); // R8
   AST_MSG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> msg_valid); // R8
   AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid |-> !(st_sent && st_coal)); // R12
   AST_NO_STATUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !st_valid |-> (!st_sent && !st_coal)); // R10
endmodule

// File: tb/test_irq_pin_service.sv
module test_irq_pin_service;
   localparam int PER = 10;
   localparam int N   = 24;
   localparam int VW  = 8;
   localparam int DW  = 8;
   localparam int IW  = 5;
   localparam logic [DW-1:0] BOOT = 8'h5A;

   logic clk = 1'b0;
   logic rst_n;
   always #(PER/2) clk = ~clk;

   logic          ev_valid, ev_level, rs_valid, msg_ready;
   logic [IW-1:0] ev_idx, rs_idx;
   logic [N*VW-1:0] cfg_vector;
   logic [N*DW-1:0] cfg_dest;
   logic [N*3-1:0]  cfg_dmode;
   logic [N-1:0]    cfg_logical, cfg_active_low, cfg_level_trig, cfg_mask, cfg_rirr;
   logic [N-1:0]    irr, rirr_set;
   logic            st_valid, st_sent, st_coal, msg_valid, msg_logical, msg_level;
   logic [IW-1:0]   msg_pin;
   logic [VW-1:0]   msg_vector;
   logic [DW-1:0]   msg_dest;
   logic [2:0]      msg_dmode;

   logic [VW-1:0] c_vec [N];
   logic [DW-1:0] c_dst [N];
   logic [2:0]    c_dm  [N];
   logic          c_log [N];
   logic          c_pol [N];
   logic          c_lvl [N];
   logic          c_msk [N];
   logic          c_rirr[N];

   always_comb begin
      for (int i = 0; i < N; i++) begin
         cfg_vector[i*VW +: VW] = c_vec[i];
         cfg_dest[i*DW +: DW]   = c_dst[i];
         cfg_dmode[i*3 +: 3]    = c_dm[i];
         cfg_logical[i]         = c_log[i];
         cfg_active_low[i]      = c_pol[i];
         cfg_level_trig[i]      = c_lvl[i];
         cfg_mask[i]            = c_msk[i];
         cfg_rirr[i]            = c_rirr[i];
      end
   end

   irq_pin_service #(
      .NUM_PINS (N), .VEC_W (VW), .DEST_W (DW), .IDX_W (IW),
      .ARB_IMPL (0), .PIN0_FIXED (1'b1), .BOOT_DEST (BOOT)
   ) i_irq_pin_service (
      .clk (clk), .rst_n (rst_n),
      .ev_valid (ev_valid), .ev_idx (ev_idx), .ev_level (ev_level),
      .rs_valid (rs_valid), .rs_idx (rs_idx),
      .cfg_vector (cfg_vector), .cfg_dest (cfg_dest), .cfg_dmode (cfg_dmode),
      .cfg_logical (cfg_logical), .cfg_active_low (cfg_active_low),
      .cfg_level_trig (cfg_level_trig), .cfg_mask (cfg_mask), .cfg_rirr (cfg_rirr),
      .irr (irr), .rirr_set (rirr_set),
      .st_valid (st_valid), .st_sent (st_sent), .st_coal (st_coal),
      .msg_valid (msg_valid), .msg_ready (msg_ready), .msg_pin (msg_pin),
      .msg_vector (msg_vector), .msg_dest (msg_dest), .msg_logical (msg_logical),
      .msg_dmode (msg_dmode), .msg_level (msg_level)
   );

   int nchk = 0;
   int nfail = 0;

   // reference model state
   bit m_irr [N], m_pend [N], n_irr [N], n_pend [N];
   bit m_stv, m_sent, m_coal, m_lastlvl;
   bit n_stv, n_sent, n_coal, n_lastlvl;
   int m_g;
   logic [N-1:0] exp_rs_set;

   task automatic chk(input string tag, input string what,
                      input logic [63:0] got, input logic [63:0] exp);
      nchk++;
      if (got !== exp) begin
         nfail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
      end
   endtask

   task automatic compare_all();
      logic [N-1:0] ei;
      m_g = -1;
      for (int i = 0; i < N; i++)
         if (m_pend[i] && m_g < 0) m_g = i;
      chk("R8", "msg_valid", 64'(msg_valid), 64'(m_g >= 0));
      exp_rs_set = '0;
      if (m_g >= 0) begin
         chk("R8", "msg_pin", 64'(msg_pin), 64'(m_g));
         chk("R7", "msg_vector", 64'(msg_vector), 64'(c_vec[m_g]));
         chk("R7", "msg_dmode", 64'(msg_dmode), 64'(c_dm[m_g]));
         chk("R7", "msg_level", 64'(msg_level), 64'(c_lvl[m_g]));
         if (m_g == 0) begin
            chk("R9", "msg_dest", 64'(msg_dest), 64'(BOOT));
            chk("R9", "msg_logical", 64'(msg_logical), 64'd0);
         end else begin
            chk("R7", "msg_dest", 64'(msg_dest), 64'(c_dst[m_g]));
            chk("R7", "msg_logical", 64'(msg_logical), 64'(c_log[m_g]));
         end
         if (msg_ready && c_lvl[m_g]) exp_rs_set[m_g] = 1'b1;
      end
      chk("R6", "rirr_set", 64'(rirr_set), 64'(exp_rs_set));
      for (int i = 0; i < N; i++) ei[i] = m_irr[i];
      chk("R1", "irr", 64'(irr), 64'(ei));
      chk("R12", "st_valid", 64'(st_valid), 64'(m_stv));
      chk(m_lastlvl ? "R4" : "R3", "st_sent", 64'(st_sent), 64'(m_sent));
      chk(m_lastlvl ? "R4" : "R3", "st_coal", 64'(st_coal), 64'(m_coal));
   endtask

   task automatic model_next(input bit ev_v, input int ev_i, input bit ev_l,
                             input bit rs_v, input int rs_i, input bit rdy);
      bit take;
      take = (m_g >= 0) && rdy;
      n_stv = ev_v && (ev_i < N);
      n_sent = 1'b0;
      n_coal = 1'b0;
      n_lastlvl = (ev_i < N) ? c_lvl[ev_i] : 1'b0;
      for (int p = 0; p < N; p++) begin
         bit hit, eff, ok, rsq, fire;
         hit  = ev_v && (ev_i == p);
         eff  = ev_l ^ c_pol[p];
         ok   = c_lvl[p] ? !(c_rirr[p] || m_pend[p]) : !m_irr[p];
         rsq  = rs_v && (rs_i == p) && c_lvl[p] && m_irr[p] && !c_rirr[p] && !m_pend[p];
         fire = ((hit && eff && ok) || rsq) && !c_msk[p];
         n_pend[p] = fire ? 1'b1 : ((take && m_g == p) ? 1'b0 : m_pend[p]);
         n_irr[p]  = hit ? eff : m_irr[p];
         if (hit && eff && ok && !c_msk[p]) n_sent = 1'b1;
         if (hit && eff && !ok) n_coal = 1'b1;
      end
   endtask

   task automatic step(input bit ev_v, input int ev_i, input bit ev_l,
                       input bit rs_v, input int rs_i, input bit rdy);
      @(negedge clk);
      ev_valid  = ev_v;
      ev_idx    = IW'(ev_i);
      ev_level  = ev_l;
      rs_valid  = rs_v;
      rs_idx    = IW'(rs_i);
      msg_ready = rdy;
      #1;
      compare_all();
      model_next(ev_v, ev_i, ev_l, rs_v, rs_i, rdy);
      @(posedge clk);
      #1;
      for (int p = 0; p < N; p++) begin
         m_irr[p]  = n_irr[p];
         m_pend[p] = n_pend[p];
         if (exp_rs_set[p]) c_rirr[p] = 1'b1;
      end
      m_stv = n_stv; m_sent = n_sent; m_coal = n_coal; m_lastlvl = n_lastlvl;
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
   endtask

   initial begin
      #(PER * 200000);
      nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
   end

   initial begin
      logic [N-1:0] irr_snap;
      rst_n = 1'b0;
      ev_valid = 0; ev_idx = '0; ev_level = 0;
      rs_valid = 0; rs_idx = '0; msg_ready = 0;
      for (int i = 0; i < N; i++) begin
         c_vec[i] = VW'(8'h20 + i);
         c_dst[i] = DW'(i + 1);
         c_dm[i]  = 3'(i % 8);
         c_log[i] = i[0];
         c_pol[i] = 0; c_lvl[i] = 0; c_msk[i] = 0; c_rirr[i] = 0;
         m_irr[i] = 0; m_pend[i] = 0;
      end
      m_stv = 0; m_sent = 0; m_coal = 0; m_lastlvl = 0; m_g = -1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R13: reset state
      chk("R13", "irr after reset", 64'(irr), 64'd0);
      chk("R13", "msg_valid after reset", 64'(msg_valid), 64'd0);
      chk("R13", "st_valid after reset", 64'(st_valid), 64'd0);

      // edge pin 3: fire, coalesce, clear, fire again
      step(1, 3, 1, 0, 0, 0);
      chk("R3", "edge first rise sent", 64'(st_sent), 64'd1);
      step(1, 3, 1, 0, 0, 0);
      chk("R3", "edge repeat coalesced", 64'(st_coal), 64'd1);
      step(1, 3, 0, 0, 0, 0);
      chk("R2", "low level no sent", 64'(st_sent), 64'd0);
      chk("R2", "low level no coal", 64'(st_coal), 64'd0);
      chk("R2", "low level clears irr", 64'(irr[3]), 64'd0);
      step(1, 3, 1, 0, 0, 0);
      chk("R3", "edge rise after clear sent", 64'(st_sent), 64'd1);
      step(0, 0, 0, 0, 0, 1);
      chk("R8", "drained", 64'(msg_valid), 64'd0);

      // pin 0 fixed routing
      c_log[0] = 1; c_dst[0] = 8'h33;
      step(1, 0, 1, 0, 0, 0);
      chk("R9", "pin0 dest", 64'(msg_dest), 64'(BOOT));
      chk("R9", "pin0 physical", 64'(msg_logical), 64'd0);

      // lowest first
      step(1, 5, 1, 0, 0, 0);
      chk("R8", "lowest offered", 64'(msg_pin), 64'd0);
      step(0, 0, 0, 0, 0, 1);
      chk("R8", "next pin offered", 64'(msg_pin), 64'd5);
      step(0, 0, 0, 0, 0, 1);
      chk("R8", "all drained", 64'(msg_valid), 64'd0);

      // level pin 7, active low
      c_lvl[7] = 1; c_pol[7] = 1;
      step(1, 7, 0, 0, 0, 0);
      chk("R4", "level sent", 64'(st_sent), 64'd1);
      chk("R1", "active low sets irr", 64'(irr[7]), 64'd1);
      step(0, 0, 0, 0, 0, 1);   // acceptance: rirr_set compared (R6)
      step(1, 7, 0, 0, 0, 0);
      chk("R4", "remote flag coalesces", 64'(st_coal), 64'd1);
      chk("R4", "no message while flag set", 64'(msg_valid), 64'd0);
      c_rirr[7] = 0;
      step(0, 0, 0, 1, 7, 0);
      chk("R11", "re-service queued", 64'(msg_valid), 64'd1);
      chk("R11", "re-service pin", 64'(msg_pin), 64'd7);
      step(0, 0, 0, 0, 0, 1);

      // masked pin 9
      c_msk[9] = 1;
      step(1, 9, 1, 0, 0, 0);
      chk("R5", "masked not sent", 64'(st_sent), 64'd0);
      chk("R5", "masked not coalesced", 64'(st_coal), 64'd0);
      chk("R5", "masked no message", 64'(msg_valid), 64'd0);
      chk("R5", "masked irr set", 64'(irr[9]), 64'd1);

      // out of range
      irr_snap = irr;
      step(1, 30, 1, 1, 27, 0);
      chk("R10", "no status", 64'(st_valid), 64'd0);
      chk("R10", "irr unchanged", 64'(irr), 64'(irr_snap));
      chk("R10", "no message", 64'(msg_valid), 64'd0);

      // random traffic
      for (int k = 0; k < 4000; k++) begin
         bit ev_v, ev_l, rs_v, rdy;
         int ev_i, rs_i;
         ev_v = ($urandom % 10) < 6;
         ev_i = $urandom % 32;
         ev_l = $urandom % 2;
         rs_v = ($urandom % 10) == 0;
         rs_i = $urandom % 32;
         rdy  = $urandom % 2;
         if (($urandom % 20) == 0) begin
            int p;
            p = $urandom % N;
            c_rirr[p] = 0;
            rs_v = 1; rs_i = p;
         end
         if (($urandom % 33) == 0) begin
            int p;
            p = $urandom % N;
            c_vec[p] = VW'($urandom);
            c_dst[p] = DW'($urandom);
            c_dm[p]  = 3'($urandom);
            c_log[p] = 1'($urandom);
            c_pol[p] = 1'($urandom);
            c_lvl[p] = 1'($urandom);
            c_msk[p] = ($urandom % 4) == 0;
         end
         step(ev_v, ev_i, ev_l, rs_v, rs_i, rdy);
      end

      summary();
      $finish;
   end
endmodule